// File: doc/BRIEF.md
# UART receive/transmit FIFO control with occupancy count

This block sits between a UART's serial shifters and its register interface. It holds the received bytes in a receive queue, each byte stored beside a three-bit error tag (parity, framing, break) supplied by the receive shifter. It also holds outgoing bytes in a transmit queue. It keeps a live byte count of the receive queue, presented as a register word. It keeps sticky line-status error bits, which a line-status read clears.

A single control-register write port programs the block. The enable bit switches both queues between FIFO mode, which holds up to the full depth, and non-FIFO mode, which holds a single byte. Two flush bits empty the receive queue or the transmit queue. A two-bit field selects the receive level at which the received-data-available condition is raised. The flush bits and the level field are accepted only when the same write also sets the enable bit. Flushing removes the queued bytes and their tags. It does not remove the latched line-status errors.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: `occ_word` holds the receive byte count (0 to 64) in bits 6:0, and its upper bits are zero. The count rises by one for each accepted byte and falls by one for each byte read out (`rx_pop` while non-empty).
- R2: A byte pushed while the receive queue is at capacity is dropped, and line-status bit 0 (overrun) is set. This holds even if a pop happens in the same cycle.
- R3: A control write with bit 0 = 1 and bit 1 = 1 empties the receive queue. On the next cycle the count is 0 and `data_ready`, `fifo_err` and `rda_irq` are low. A byte pushed in the same cycle as the flush is discarded, and a byte pushed on the following cycle is stored.
- R4: A flush of either queue leaves the line-status bits `line_err` unchanged.
- R5: A control write with bit 0 = 0 disables FIFO mode and empties both queues. Its level field (bits 7:6) is ignored, so the read-back level field keeps its value.
- R6: Any write that changes the enable bit empties both queues, including a 0-to-1 change.
- R7: In non-FIFO mode each queue holds at most one byte. The receive count reads 0 or 1, and a second byte is dropped with overrun set.
- R8: `fifo_err` is high exactly when FIFO mode is on and at least one stored receive byte has a non-zero tag. It falls once the last tagged byte has been read out.
- R9: In FIFO mode `rda_irq` is high when the receive count is at least the level chosen by control bits 7:6 (00 gives 1, 01 gives 8, 10 gives 16, 11 gives 32). In non-FIFO mode it is high when one byte is held.
- R10: `line_err` bits are overrun (bit 0), parity (bit 1, from tag bit 0), framing (bit 2, from tag bit 1) and break (bit 3, from tag bit 2). Each bit is set by a pushed byte carrying that tag bit and cleared by `lsr_rd`. A set in the same cycle as `lsr_rd` wins.
- R11: A control write with bit 0 = 1 and bit 2 = 1 empties the transmit queue and leaves the receive queue unchanged.
- R12: After reset FIFO mode is off, `ctl_rdata` reads 0 (flush bits always read 0, with the enable in bit 0 and the level in bits 7:6), and both counts are 0.
- R13: Receive bytes and their tags leave in arrival order. `rx_data`/`rx_tag_out` show the oldest stored entry, and `tx_data` shows the oldest transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control write data: enable bit 0, receive flush bit 1, transmit flush bit 2, level bits 7:6 |
| ctl_rdata | output | 8 | Control read-back: level bits 7:6, enable bit 0, all other bits 0 |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_tag_in | input | 3 | Error tag of the received byte: parity, framing, break |
| rx_pop | input | 1 | Read of the receive data register |
| rx_data | output | 8 | Oldest stored receive byte |
| rx_tag_out | output | 3 | Tag of the oldest stored receive byte |
| occ_word | output | 32 | Receive occupancy register word |
| data_ready | output | 1 | At least one receive byte is stored |
| fifo_err | output | 1 | Some stored receive byte carries an error tag |
| rda_irq | output | 1 | Received-data-available condition |
| lsr_rd | input | 1 | Line-status read; clears the sticky bits |
| line_err | output | 4 | Sticky overrun, parity, framing and break bits |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_byte | input | 8 | Transmit byte |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_count | output | 7 | Transmit queue count |
| tx_ready | output | 1 | Transmit queue is non-empty |

## Verification
A wrong pointer or count shows up at `occ_word`, and at `rx_data` or `tx_data`, on the cycle after the push or pop that disturbed it. A stale tag counter shows as `fifo_err` staying high after the last tagged byte leaves the queue, or rising when no tagged byte is held. Flush or mode-switch decode errors show one cycle after the control write. They appear either as a non-zero count or as the read-back level changing on a write that does not set the enable bit. A bench model of both queues and the sticky bits compares all outputs every cycle, so a divergence is seen within one cycle of its cause.

// File: rtl/uart_fifo_pkg.sv
// Shared constants and types for the UART FIFO control block.
// Assumes 8-bit characters and a three-bit per-byte error tag.
package uart_fifo_pkg;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;
    localparam int LSR_W  = 4;
    localparam int CTL_W  = 8;

    // Control-register bit positions (decoded by software, so fixed).
    localparam int CTL_EN     = 0;
    localparam int CTL_RXCLR  = 1;
    localparam int CTL_TXCLR  = 2;
    localparam int CTL_LVL_LO = 6;

    // Line-status bit positions.
    localparam int LS_OVR = 0;
    localparam int LS_PAR = 1;
    localparam int LS_FRM = 2;
    localparam int LS_BRK = 3;

    // One receive queue entry: tag above data.
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } rx_slot_t;

    // Receive level selected by the two-bit control field.
    function automatic int rda_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 32;
        endcase
    endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
// Circular queue with a flush input and a one-entry mode.
// Assumes: flush beats push and pop in the same cycle; a push at
// capacity is dropped (reported on overflow) even with a concurrent pop.
module uart_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             one_deep,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             overflow
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full;

    // Capacity depends on the mode: one byte or the full depth.
    assign full     = one_deep ? (count != '0) : (count == CNT_W'(DEPTH));
    assign push_ok  = push & ~full & ~flush;
    assign pop_ok   = pop & (count != '0) & ~flush;
    assign overflow = push & full & ~flush;
    assign dout     = mem[rd_ptr];

    // Advance a pointer with explicit wrap so any depth works.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and count bookkeeping; flush returns to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // Storage write; contents need no reset since count gates use.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/uart_fifo_ctl_dec.sv
// Control-register decode: holds the mode bit and level field and
// produces one-cycle flush requests for each queue.
// Assumes: flush and level bits count only when the enable bit is 1
// in the same write; writing enable = 0 or flipping it clears both.
module uart_fifo_ctl_dec
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic             en,
    output logic [1:0]       lvl_sel,
    output logic             rx_clr,
    output logic             tx_clr
);
    logic armed, flip, drop_all;
    logic unused_ctl_bits;

    assign unused_ctl_bits = ^wdata[5:3];

    // Classify the write: armed, mode change, or disable.
    always_comb begin
        armed    = wr & wdata[CTL_EN];
        flip     = wr & (wdata[CTL_EN] != en);
        drop_all = (wr & ~wdata[CTL_EN]) | flip;
        rx_clr   = drop_all | (armed & wdata[CTL_RXCLR]);
        tx_clr   = drop_all | (armed & wdata[CTL_TXCLR]);
    end

    // Programmable state: mode on every write, level only when armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            lvl_sel <= 2'd0;
        end else begin
            if (wr)    en      <= wdata[CTL_EN];
            if (armed) lvl_sel <= wdata[CTL_LVL_LO +: 2];
        end
    end
endmodule

// File: rtl/uart_line_sticky.sv
// Sticky line-status error bits, set by received tags and overrun,
// cleared by a line-status read; a set in the clearing cycle wins.
// Assumes tags are reported with every pushed byte, stored or not.
module uart_line_sticky
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] tag,
    input  logic             ovr,
    input  logic             rd_clr,
    output logic [LSR_W-1:0] line_err
);
    logic [LSR_W-1:0] set_v;

    // Map tag bits and overrun onto line-status positions.
    always_comb begin
        set_v         = '0;
        set_v[LS_OVR] = ovr;
        set_v[LS_PAR] = push & tag[0];
        set_v[LS_FRM] = push & tag[1];
        set_v[LS_BRK] = push & tag[2];
    end

    // Accumulate errors until read.
    always_ff @(posedge clk) begin
        if (!rst_n) line_err <= '0;
        else        line_err <= (rd_clr ? '0 : line_err) | set_v;
    end
endmodule

// File: rtl/uart_fifo_ctrl.sv
// Top of the UART FIFO control block: receive queue with per-byte tags,
// transmit queue, control decode, occupancy word and status outputs.
// Assumes shifters outside drive rx_push/tx_pop; flushes never touch them.
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    parameter int REG_W    = 32,
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1),
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    output logic [CTL_W-1:0]    ctl_rdata,
    input  logic                rx_push,
    input  logic [DATA_W-1:0]   rx_byte,
    input  logic [TAG_W-1:0]    rx_tag_in,
    input  logic                rx_pop,
    output logic [DATA_W-1:0]   rx_data,
    output logic [TAG_W-1:0]    rx_tag_out,
    output logic [REG_W-1:0]    occ_word,
    output logic                data_ready,
    output logic                fifo_err,
    output logic                rda_irq,
    input  logic                lsr_rd,
    output logic [LSR_W-1:0]    line_err,
    input  logic                tx_push,
    input  logic [DATA_W-1:0]   tx_byte,
    input  logic                tx_pop,
    output logic [DATA_W-1:0]   tx_data,
    output logic [TX_CNT_W-1:0] tx_count,
    output logic                tx_ready
);
    logic                en, rx_clr, tx_clr;
    logic [1:0]          lvl_sel;
    rx_slot_t            rx_in, rx_head;
    logic [RX_CNT_W-1:0] rx_cnt, err_cnt;
    logic                rx_push_ok, rx_pop_ok, rx_ovr;
    logic                unused_tx_push_ok, unused_tx_pop_ok, unused_tx_ovr;

    uart_fifo_ctl_dec u_dec (
        .clk, .rst_n, .wr(ctl_wr), .wdata(ctl_wdata),
        .en, .lvl_sel, .rx_clr, .tx_clr
    );

    assign rx_in = '{tag: rx_tag_in, data: rx_byte};

    uart_byte_fifo #(.W($bits(rx_slot_t)), .DEPTH(RX_DEPTH)) u_rxq (
        .clk, .rst_n, .flush(rx_clr), .one_deep(~en),
        .push(rx_push), .din(rx_in), .pop(rx_pop), .dout(rx_head),
        .count(rx_cnt), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .overflow(rx_ovr)
    );

    uart_byte_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk, .rst_n, .flush(tx_clr), .one_deep(~en),
        .push(tx_push), .din(tx_byte), .pop(tx_pop), .dout(tx_data),
        .count(tx_count), .push_ok(unused_tx_push_ok),
        .pop_ok(unused_tx_pop_ok), .overflow(unused_tx_ovr)
    );

    uart_line_sticky u_lsr (
        .clk, .rst_n, .push(rx_push), .tag(rx_tag_in), .ovr(rx_ovr),
        .rd_clr(lsr_rd), .line_err
    );

    // Count of stored receive bytes whose tag is non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) err_cnt <= '0;
        else err_cnt <= err_cnt
                      + RX_CNT_W'(rx_push_ok & (|rx_tag_in))
                      - RX_CNT_W'(rx_pop_ok & (|rx_head.tag));
    end

    // Status and register read-back.
    always_comb begin
        rx_data    = rx_head.data;
        rx_tag_out = rx_head.tag;
        occ_word   = REG_W'(rx_cnt);
        data_ready = (rx_cnt != '0);
        fifo_err   = en & (err_cnt != '0);
        rda_irq    = en ? (int'(rx_cnt) >= rda_level(lvl_sel)) : (rx_cnt != '0);
        tx_ready   = (tx_count != '0);
        ctl_rdata  = '0;
        ctl_rdata[CTL_EN]          = en;
        ctl_rdata[CTL_LVL_LO +: 2] = lvl_sel;
    end
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Port-level assertions for uart_fifo_ctrl, attached by bind below.
module uart_fifo_ctrl_chk #(
    parameter int RX_DEPTH = 64,
    parameter int TX_DEPTH = 64,
    parameter int REG_W    = 32,
    localparam int RCW = $clog2(RX_DEPTH + 1),
    localparam int TCW = $clog2(TX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [7:0]       ctl_wdata,
    input logic [7:0]       ctl_rdata,
    input logic             rx_push,
    input logic             lsr_rd,
    input logic [REG_W-1:0] occ_word,
    input logic             data_ready,
    input logic             fifo_err,
    input logic             rda_irq,
    input logic [3:0]       line_err,
    input logic [TCW-1:0]   tx_count
);
    p_occ_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        occ_word <= REG_W'(RX_DEPTH));

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=>
            ({1'b0, occ_word[RCW-1:0]} <= {1'b0, $past(occ_word[RCW-1:0])} + 1'b1) &&
            ({1'b0, $past(occ_word[RCW-1:0])} <= {1'b0, occ_word[RCW-1:0]} + 1'b1));

    p_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && ctl_rdata[0] && !ctl_wr && occ_word == REG_W'(RX_DEPTH)
        |=> line_err[0]);

    p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_wdata[0] && ctl_wdata[1]
        |=> occ_word == '0 && !data_ready && !fifo_err && !rda_irq);

    p_sticky_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !lsr_rd |=> (line_err & $past(line_err)) == $past(line_err));

    p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wdata[0]
        |=> occ_word == '0 && tx_count == '0 && !ctl_rdata[0] &&
            ctl_rdata[7:6] == $past(ctl_rdata[7:6]));

    p_single_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> occ_word <= REG_W'(1) && tx_count <= TCW'(1));

    p_no_err_nonfifo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> !fifo_err);

    p_flush_bits_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5:1] == 5'd0);
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .REG_W(REG_W)
) u_chk (.*);

// File: tb/uart_fifo_ctrl_bench.sv
// Bench: reference model of both queues, mode, level and sticky bits;
// directed corner cases then seeded random traffic, compared each cycle.
module uart_fifo_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ctl_wr = 0, rx_push = 0, rx_pop = 0, lsr_rd = 0;
    logic        tx_push = 0, tx_pop = 0;
    logic [7:0]  ctl_wdata = 0, rx_byte = 0, tx_byte = 0;
    logic [2:0]  rx_tag_in = 0;
    logic [7:0]  ctl_rdata, rx_data, tx_data;
    logic [2:0]  rx_tag_out;
    logic [31:0] occ_word;
    logic        data_ready, fifo_err, rda_irq, tx_ready;
    logic [3:0]  line_err;
    logic [6:0]  tx_count;

    uart_fifo_ctrl u_uart_fifo_ctrl (.*);

    always #(CLK_P/2) clk = ~clk;

    int vectors = 0, fails = 0;
    bit done = 0;
    bit [10:0] mrq[$];
    bit [7:0]  mtq[$];
    bit        m_en = 0;
    bit [1:0]  m_lvl = 0;
    bit [3:0]  m_ls = 0;

    function automatic int lvl_n(bit [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 16 : 32;
    endfunction

    function automatic bit any_tag();
        foreach (mrq[k]) if (mrq[k][10:8] != 0) return 1;
        return 0;
    endfunction

    task automatic chk(string req, string nm, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int n = mrq.size();
        chk("R1",  "occ_word",   int'(occ_word), n);
        chk("R3",  "data_ready", data_ready, int'(n != 0));
        if (n != 0) begin
            chk("R13", "rx_data", rx_data, mrq[0][7:0]);
            chk("R13", "rx_tag",  rx_tag_out, mrq[0][10:8]);
        end
        chk("R8",  "fifo_err",  fifo_err, int'(m_en && any_tag()));
        chk("R9",  "rda_irq",   rda_irq, int'(m_en ? (n >= lvl_n(m_lvl)) : (n >= 1)));
        chk("R10", "line_err",  line_err, m_ls);
        chk("R12", "ctl_rdata", ctl_rdata, {m_lvl, 5'b0, m_en});
        chk("R11", "tx_count",  tx_count, mtq.size());
        chk("R11", "tx_ready",  tx_ready, int'(mtq.size() != 0));
        if (mtq.size() != 0) chk("R13", "tx_data", tx_data, mtq[0]);
    endtask

    // Advance the model by one clock with the given inputs.
    task automatic model(bit wr, bit [7:0] wd, bit ps, bit [7:0] b, bit [2:0] tg,
                         bit pp, bit lr, bit tps, bit [7:0] tb, bit tpp);
        bit crx = wr && (!wd[0] || wd[0] != m_en || wd[1]);
        bit ctx = wr && (!wd[0] || wd[0] != m_en || wd[2]);
        int cap = m_en ? 64 : 1;
        bit ovr = 0;
        bit full;
        if (crx) mrq.delete();
        else begin
            full = (mrq.size() >= cap);
            if (pp && mrq.size() != 0) void'(mrq.pop_front());
            if (ps && !full) mrq.push_back({tg, b});
            ovr = ps && full;
        end
        if (ctx) mtq.delete();
        else begin
            full = (mtq.size() >= cap);
            if (tpp && mtq.size() != 0) void'(mtq.pop_front());
            if (tps && !full) mtq.push_back(tb);
        end
        m_ls = (lr ? 4'b0 : m_ls) | {ps & tg[2], ps & tg[1], ps & tg[0], ovr};
        if (wr) begin
            if (wd[0]) m_lvl = wd[7:6];
            m_en = wd[0];
        end
    endtask

    // Check last cycle's result, then drive and model one cycle.
    task automatic cyc(bit wr, bit [7:0] wd, bit ps, bit [7:0] b, bit [2:0] tg,
                       bit pp, bit lr, bit tps, bit [7:0] tb, bit tpp);
        @(negedge clk);
        check_all();
        ctl_wr = wr; ctl_wdata = wd; rx_push = ps; rx_byte = b; rx_tag_in = tg;
        rx_pop = pp; lsr_rd = lr; tx_push = tps; tx_byte = tb; tx_pop = tpp;
        model(wr, wd, ps, b, tg, pp, lr, tps, tb, tpp);
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic push(bit [7:0] b, bit [2:0] tg); cyc(0, 0, 1, b, tg, 0, 0, 0, 0, 0); endtask
    task automatic wctl(bit [7:0] wd); cyc(1, wd, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle();                                   // R12 reset state
        // R7: non-FIFO single slot, second byte overruns
        push(8'hA1, 0); push(8'hA2, 0); idle();
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 8'h11, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 8'h12, 0);    // R7 tx single slot
        // R6: enabling drops held bytes
        push(8'hB0, 0); wctl(8'h01); idle();
        // R1 R2 R13: fill past capacity
        for (int i = 0; i < 66; i++) push(8'(i + 3), (i % 9 == 0) ? 3'd2 : 3'd0);
        idle();
        // R3 R4: flush with simultaneous push, then a following byte lands
        cyc(1, 8'h03, 1, 8'hEE, 3'd4, 0, 0, 0, 0, 0);
        push(8'h5A, 0); idle();
        // R9: level 8
        wctl(8'h41);
        for (int i = 0; i < 9; i++) push(8'(i), 0);
        idle();
        // R5: disable write with flush bits and new level is ignored but clears
        wctl(8'hC6); idle();
        wctl(8'h81); idle();                      // level 16
        // R11: tx flush leaves rx
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 8'(i), 0, 0, 0, 1, 8'(40 + i), 0);
        wctl(8'h85); idle();
        // R8: tagged byte leaves, flag drops
        wctl(8'h83);
        push(8'h77, 3'd1); push(8'h78, 0); push(8'h79, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0); idle();
        // R10: set wins over clear
        cyc(0, 0, 1, 8'h33, 3'd7, 0, 1, 0, 0, 0); idle();
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0); idle();
        // Random traffic with phases
        for (int i = 0; i < 30000; i++) begin
            int ph = (i / 400) % 4;
            int pp_w = (ph == 0) ? 60 : (ph == 1) ? 20 : (ph == 2) ? 90 : 40;
            int pop_w = (ph == 0) ? 20 : (ph == 1) ? 60 : (ph == 2) ? 5 : 40;
            bit wr = ($urandom_range(0, 149) == 0);
            bit [7:0] wd = 8'($urandom());
            if ($urandom_range(0, 9) < 8) wd[0] = 1'b1;
            cyc(wr, wd,
                $urandom_range(0, 99) < pp_w, 8'($urandom()),
                ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0,
                $urandom_range(0, 99) < pop_w, $urandom_range(0, 19) == 0,
                $urandom_range(0, 99) < 35, 8'($urandom()), $urandom_range(0, 99) < 35);
        end
        idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule